// File: doc/BRIEF.md
# Interrupt Presenter Ring Matcher

This block decides whether a notification is addressed to one hardware thread and, if so, on which privilege ring it lands. It compares the notification target against the identifiers held in the thread's context for three rings: hypervisor physical, hypervisor pool and OS. The first ring that qualifies in a fixed priority order is reported. A target can name one virtual processor or a group of them. In group mode the low-order bits of the index are masked off before the compare. A second format selects a user-level delivery path that looks at the OS ring identifier only.

After a match, the block compares the notification priority with the current priority of the matched ring. It reports whether the interrupt is precluded as a flag separate from the match result. The logic is combinational and ends in one register stage. Each cycle with the input strobe high produces one result one cycle later.

Top module: `irq_ring_matcher`

## Requirements
- R1: With `fmt_user`=0 and `grp_ignore`=0, a ring matches only when `tgt_id` equals its CAM value in every bit.
- R2: With `fmt_user`=0 and `grp_ignore`=1, let k be the position of the lowest 0 bit in `tgt_id`. Bits k down to 0 are excluded from the compare, and all higher bits must be equal.
- R3: With `fmt_user`=0 and `grp_ignore`=1, a `tgt_id` of all ones matches no ring and gives a miss.
- R4: When several rings qualify, physical (code 1) wins over pool (code 2), and pool wins over OS (code 3).
- R5: A ring whose valid input (`phys_vld`, `pool_vld`, `os_vld`) is 0 never matches.
- R6: In group mode, a ring whose group-enable byte is zero is excluded. In exact mode the group-enable byte has no effect.
- R7: With `fmt_user`=1, only the user ring (code 4) can match. It requires `os_vld`=1 and an exact match of `os_cam`, and `grp_ignore` has no effect. Its preclusion uses `os_cppr`.
- R8: On a match, `precluded` is 0 when `prio` is numerically below the matched ring's CPPR, and 1 otherwise.
- R9: When nothing matches, `miss`=1, `ring`=0 and `precluded`=0. When there is a match, `miss`=0.
- R10: A result appears one cycle after `in_valid`=1 with `out_valid`=1. In cycles after `in_valid`=0, `out_valid` is 0 and `ring`, `miss` and `precluded` keep their values.
- R11: After reset, `out_valid`, `ring`, `miss` and `precluded` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Evaluate the inputs this cycle |
| fmt_user | input | 1 | 1 selects user-ring delivery |
| grp_ignore | input | 1 | 1 selects group matching |
| tgt_id | input | ID_W | Notification target identifier |
| prio | input | PRIO_W | Notification priority |
| phys_vld | input | 1 | Physical ring context valid |
| pool_vld | input | 1 | Pool ring context valid |
| os_vld | input | 1 | OS ring context valid |
| phys_cam | input | ID_W | Physical ring identifier |
| pool_cam | input | ID_W | Pool ring identifier |
| os_cam | input | ID_W | OS ring identifier |
| phys_grp | input | 8 | Physical ring group-enable byte |
| pool_grp | input | 8 | Pool ring group-enable byte |
| os_grp | input | 8 | OS ring group-enable byte |
| phys_cppr | input | PRIO_W | Physical ring current priority |
| pool_cppr | input | PRIO_W | Pool ring current priority |
| os_cppr | input | PRIO_W | OS ring current priority |
| out_valid | output | 1 | Result valid |
| ring | output | 3 | Matched ring: 0 none, 1 phys, 2 pool, 3 OS, 4 user |
| miss | output | 1 | No ring matched |
| precluded | output | 1 | Matched but priority does not beat the CPPR |

## Verification
The hardest case to reach is a group match that lands on a lower-priority ring only because a higher ring was removed by its zero group-enable byte. Two conditions must hold at once: the higher ring's identifier must match under the mask, and its enable byte must be zero. The stimulus builds a target with a known lowest-zero position and gives every ring an identifier that differs from the target only inside or just above the masked field. It then switches the physical ring's enable byte between zero and non-zero while the rest of the context stays the same, and repeats the same context in exact mode to show the byte has no effect there.

// File: rtl/irq_ring_matcher.sv
module irq_ring_matcher #(
  parameter int ID_W   = 32,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              fmt_user,
  input  logic              grp_ignore,
  input  logic [ID_W-1:0]   tgt_id,
  input  logic [PRIO_W-1:0] prio,
  input  logic              phys_vld,
  input  logic              pool_vld,
  input  logic              os_vld,
  input  logic [ID_W-1:0]   phys_cam,
  input  logic [ID_W-1:0]   pool_cam,
  input  logic [ID_W-1:0]   os_cam,
  input  logic [7:0]        phys_grp,
  input  logic [7:0]        pool_grp,
  input  logic [7:0]        os_grp,
  input  logic [PRIO_W-1:0] phys_cppr,
  input  logic [PRIO_W-1:0] pool_cppr,
  input  logic [PRIO_W-1:0] os_cppr,
  output logic              out_valid,
  output logic [2:0]        ring,
  output logic              miss,
  output logic              precluded
);
  localparam logic [2:0] RING_NONE = 3'd0;
  localparam logic [2:0] RING_PHYS = 3'd1;
  localparam logic [2:0] RING_POOL = 3'd2;
  localparam logic [2:0] RING_OS   = 3'd3;
  localparam logic [2:0] RING_USER = 3'd4;
  localparam logic [ID_W-1:0] ONE  = ID_W'(1);

  logic              grp_mode, grp_block;
  logic [ID_W-1:0]   low_zero, cmp_mask;
  logic              hit_phys, hit_pool, hit_os, hit_user;
  logic [2:0]        ring_c;
  logic [PRIO_W-1:0] cppr_c;

  assign grp_mode  = !fmt_user && grp_ignore;
  assign grp_block = grp_mode && (&tgt_id);
  assign low_zero  = ~tgt_id & (tgt_id + ONE);
  assign cmp_mask  = grp_mode ? ~(low_zero | (low_zero - ONE)) : '1;

  assign hit_phys = !fmt_user && !grp_block && phys_vld &&
                    !(grp_mode && phys_grp == 8'd0) &&
                    (((tgt_id ^ phys_cam) & cmp_mask) == '0);
  assign hit_pool = !fmt_user && !grp_block && pool_vld &&
                    !(grp_mode && pool_grp == 8'd0) &&
                    (((tgt_id ^ pool_cam) & cmp_mask) == '0);
  assign hit_os   = !fmt_user && !grp_block && os_vld &&
                    !(grp_mode && os_grp == 8'd0) &&
                    (((tgt_id ^ os_cam) & cmp_mask) == '0);
  assign hit_user = fmt_user && os_vld && (tgt_id == os_cam);

  always_comb begin
    ring_c = RING_NONE;
    cppr_c = '0;
    if (hit_phys) begin
      ring_c = RING_PHYS;
      cppr_c = phys_cppr;
    end else if (hit_pool) begin
      ring_c = RING_POOL;
      cppr_c = pool_cppr;
    end else if (hit_os) begin
      ring_c = RING_OS;
      cppr_c = os_cppr;
    end else if (hit_user) begin
      ring_c = RING_USER;
      cppr_c = os_cppr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ring      <= RING_NONE;
      miss      <= 1'b0;
      precluded <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ring      <= ring_c;
        miss      <= (ring_c == RING_NONE);
        precluded <= (ring_c != RING_NONE) && !(prio < cppr_c);
      end
    end
  end
endmodule

module irq_ring_matcher_chk #(
  parameter int ID_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            fmt_user,
  input logic            grp_ignore,
  input logic [ID_W-1:0] tgt_id,
  input logic            phys_vld,
  input logic [ID_W-1:0] phys_cam,
  input logic [7:0]      phys_grp,
  input logic            out_valid,
  input logic [2:0]      ring,
  input logic            miss,
  input logic            precluded
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(ring) && $stable(miss) && $stable(precluded))); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && miss) |-> (ring == 3'd0 && !precluded)); // R9
  AST_HIT_CODE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !miss) |-> (ring != 3'd0 && ring <= 3'd4)); // R9
  AST_EXACT_PHYS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !fmt_user && !grp_ignore && phys_vld && tgt_id == phys_cam) |=> ring == 3'd1); // R1
  AST_GRP_OFF: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !fmt_user && grp_ignore && phys_grp == 8'd0) |=> ring != 3'd1); // R6
  AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !fmt_user && grp_ignore && (&tgt_id)) |=> miss); // R3
  AST_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && fmt_user) |=> (ring == 3'd0 || ring == 3'd4)); // R7
endmodule

bind irq_ring_matcher irq_ring_matcher_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_user(fmt_user),
  .grp_ignore(grp_ignore), .tgt_id(tgt_id), .phys_vld(phys_vld),
  .phys_cam(phys_cam), .phys_grp(phys_grp), .out_valid(out_valid),
  .ring(ring), .miss(miss), .precluded(precluded)
);

// File: tb/irq_ring_matcher_tb_top.sv
module irq_ring_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, fmt_user = 1'b0, grp_ignore = 1'b0;
  logic [31:0] tgt_id = '0, phys_cam = '0, pool_cam = '0, os_cam = '0;
  logic [7:0]  prio = '0, phys_cppr = '0, pool_cppr = '0, os_cppr = '0;
  logic [7:0]  phys_grp = '0, pool_grp = '0, os_grp = '0;
  logic        phys_vld = 1'b0, pool_vld = 1'b0, os_vld = 1'b0;
  logic        out_valid, miss, precluded;
  logic [2:0]  ring;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_ring_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_user(fmt_user),
    .grp_ignore(grp_ignore), .tgt_id(tgt_id), .prio(prio),
    .phys_vld(phys_vld), .pool_vld(pool_vld), .os_vld(os_vld),
    .phys_cam(phys_cam), .pool_cam(pool_cam), .os_cam(os_cam),
    .phys_grp(phys_grp), .pool_grp(pool_grp), .os_grp(os_grp),
    .phys_cppr(phys_cppr), .pool_cppr(pool_cppr), .os_cppr(os_cppr),
    .out_valid(out_valid), .ring(ring), .miss(miss), .precluded(precluded)
  );

  task automatic chk(string req, logic [2:0] e_ring, logic e_miss, logic e_pre, logic e_ov);
    checks++;
    if (ring !== e_ring || miss !== e_miss || precluded !== e_pre || out_valid !== e_ov) begin
      failures++;
      $display("FAIL %s: got ring=%0d miss=%0b precl=%0b ov=%0b exp ring=%0d miss=%0b precl=%0b ov=%0b",
               req, ring, miss, precluded, out_valid, e_ring, e_miss, e_pre, e_ov);
    end
  endtask

  task automatic ctx_default();
    fmt_user = 0; grp_ignore = 0; prio = 8'd1;
    phys_vld = 1; pool_vld = 1; os_vld = 1;
    phys_cam = 32'hAAAA_0000; pool_cam = 32'hBBBB_0000; os_cam = 32'hCCCC_0000;
    phys_grp = 8'd1; pool_grp = 8'd1; os_grp = 8'd1;
    phys_cppr = 8'hFF; pool_cppr = 8'hFF; os_cppr = 8'hFF;
  endtask

  task automatic fire();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset", 3'd0, 0, 0, 0);
  endtask

  task automatic t_exact();
    ctx_default(); tgt_id = 32'h0000_1234; phys_cam = 32'h0000_1234;
    fire(); chk("R1 exact phys", 3'd1, 0, 0, 1);
    tgt_id = 32'h0000_1235;
    fire(); chk("R1 one-bit difference misses", 3'd0, 1, 0, 1);
  endtask

  task automatic t_order();
    ctx_default(); tgt_id = 32'h55; phys_cam = 32'h55; pool_cam = 32'h55; os_cam = 32'h55;
    fire(); chk("R4 phys first", 3'd1, 0, 0, 1);
    phys_vld = 0;
    fire(); chk("R4/R5 pool next", 3'd2, 0, 0, 1);
    pool_vld = 0;
    fire(); chk("R4/R5 os last", 3'd3, 0, 0, 1);
    os_vld = 0;
    fire(); chk("R5 no valid ring misses", 3'd0, 1, 0, 1);
  endtask

  task automatic t_group();
    ctx_default(); tgt_id = 32'h0000_0107;
    phys_cam = 32'h0000_0110; pool_cam = 32'h0000_0200; os_cam = 32'h0000_010F;
    grp_ignore = 1;
    fire(); chk("R2 group low bits masked", 3'd3, 0, 0, 1);
    grp_ignore = 0;
    fire(); chk("R1 same target exact misses", 3'd0, 1, 0, 1);
    grp_ignore = 1; os_cam = 32'h0000_0000;
    fire(); chk("R2 bit above mask compared", 3'd0, 1, 0, 1);
  endtask

  task automatic t_grp_enable();
    ctx_default(); tgt_id = 32'h0000_0107; grp_ignore = 1;
    phys_cam = 32'h0000_0108; os_cam = 32'h0000_0100; phys_grp = 8'd0;
    fire(); chk("R6 zero enable skips phys", 3'd3, 0, 0, 1);
    phys_grp = 8'd5;
    fire(); chk("R6 enabled phys wins", 3'd1, 0, 0, 1);
    grp_ignore = 0; phys_grp = 8'd0; phys_cam = 32'h0000_0107;
    fire(); chk("R6 enable byte unused in exact", 3'd1, 0, 0, 1);
  endtask

  task automatic t_all_ones();
    ctx_default(); tgt_id = 32'hFFFF_FFFF; grp_ignore = 1;
    phys_cam = 32'hFFFF_FFFF; pool_cam = 32'hFFFF_FFFF; os_cam = 32'hFFFF_FFFF;
    fire(); chk("R3 all-ones group misses", 3'd0, 1, 0, 1);
    grp_ignore = 0;
    fire(); chk("R1 all-ones exact matches", 3'd1, 0, 0, 1);
  endtask

  task automatic t_user();
    ctx_default(); fmt_user = 1; tgt_id = 32'h0000_0042;
    phys_cam = 32'h0000_0042; os_cam = 32'h0000_0042;
    fire(); chk("R7 user ring only", 3'd4, 0, 0, 1);
    os_cam = 32'h0000_0040; grp_ignore = 1;
    fire(); chk("R7 user ignores group flag", 3'd0, 1, 0, 1);
    os_cam = 32'h0000_0042; os_vld = 0;
    fire(); chk("R7 user needs os valid", 3'd0, 1, 0, 1);
    os_vld = 1; prio = 8'd3; os_cppr = 8'd3; phys_cppr = 8'd9;
    fire(); chk("R7/R8 user uses os cppr", 3'd4, 0, 1, 1);
  endtask

  task automatic t_precl();
    ctx_default(); tgt_id = 32'h77; phys_cam = 32'h77; phys_cppr = 8'd5; os_cppr = 8'd0;
    prio = 8'd4;
    fire(); chk("R8 below cppr", 3'd1, 0, 0, 1);
    prio = 8'd5;
    fire(); chk("R8 equal cppr", 3'd1, 0, 1, 1);
    prio = 8'd6;
    fire(); chk("R8 above cppr", 3'd1, 0, 1, 1);
    tgt_id = 32'h78;
    fire(); chk("R9 miss clears precluded", 3'd0, 1, 0, 1);
  endtask

  task automatic t_hold();
    ctx_default(); tgt_id = 32'h99; pool_cam = 32'h99; prio = 8'd0;
    fire(); chk("R10 one-cycle result", 3'd2, 0, 0, 1);
    tgt_id = 32'h1; pool_cam = 32'h2;
    @(negedge clk); chk("R10 idle holds", 3'd2, 0, 0, 0);
    @(negedge clk); chk("R10 idle holds later", 3'd2, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_exact(); t_order(); t_group(); t_grp_enable();
    t_all_ones(); t_user(); t_precl(); t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule